// File: doc/BRIEF.md
# Dual Comparator Control and Routing

This block is the digital side of a pair of analog comparators. Software controls it through one 32-bit control/status word, which is always written and read whole. The block drives the analog controls: the first comparator's enable, the second comparator's inverting-input code, its speed and four pull-resistor enables. It brings the two raw comparator decisions safely into the clock domain and shows them as status bits.

The second comparator has no separate enable bit. Its inverting-input code switches it on whenever the code is non-zero. A 3-bit routing code sends the second comparator's synchronised result to one of seven timer trigger inputs, or to none of them. Each comparator drives an event line, and so does a window detector that combines the two results. Each event line fires on rising edges, falling edges or both, as software chooses.

An external acquisition-complete strobe sets a sticky flag. Software clears that flag by writing the word with the flag's interrupt-enable bit at zero.

Top module: `dualcmp_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_data_o` reads 0 and every output is low.
- R2: A write stores these bits of `wr_data_i`, and they read back unchanged on `rd_data_o`: 31, 29, 28:26, 23:16, 12, 5:0. Bits 25:24, 15:14, 11:8 and 6 always read 0. Bits 30, 13 and 7 are not affected by writes.
- R3: `cmp2_en_o` is high exactly when field 20:18 is non-zero, and `cmp2_insel_o` equals that field. The field can be rewritten while the comparator is on. When the field is zero, status bit 13 reads 0.
- R4: Status bit 7 shows `cmp1_raw_i` and bit 13 shows `cmp2_raw_i`, each through two synchroniser flops. The value an input holds at clock edge k becomes visible after edge k+1. Bit 7 is forced to 0 while bit 4 (first comparator enable) is 0, and bit 13 is forced to 0 while the comparator 2 select is off.
- R5: Field 23:21 is the routing code. For codes 0 to 6, `route_o[code]` carries status bit 13, one clock later. In order, these lines are: timer A capture 4, timer A ref-clear, timer B capture 4, timer B ref-clear, timer C capture 4, timer C ref-clear, timer D capture 1. Code 7 holds all of `route_o` low. At most one bit of `route_o` is ever high.
- R6: `evt1_o` and `evt2_o` give a one-cycle pulse one clock after status bit 7 (or bit 13) changes. A 0-to-1 change counts when its rising-enable bit is set: bit 26 for comparator 1, bit 28 for comparator 2. A 1-to-0 change counts when its falling-enable bit is set: bit 27 for comparator 1, bit 31 for comparator 2.
- R7: The window condition is true when bit 17 is set, status bit 7 is 1 and status bit 13 is 0. `win_o` shows the condition one clock later. `evtw_o` pulses one clock after the condition changes, on rises if bit 16 is set and on falls if bit 5 is set.
- R8: Bit 30 is set by a `acq_done_i` high at a clock edge. It is cleared by a write whose bit 29 is 0. If both happen on the same edge, the set wins. `acq_irq_o` equals bit 30 AND bit 29.
- R9: `cmp2_fast_o` follows bit 12, `cmp1_en_o` follows bit 4, and `pull_o` follows bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Word write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Control/status word |
| cmp1_raw_i | input | 1 | Asynchronous comparator 1 decision |
| cmp2_raw_i | input | 1 | Asynchronous comparator 2 decision |
| acq_done_i | input | 1 | Acquisition-complete strobe |
| cmp1_en_o | output | 1 | Comparator 1 enable |
| cmp2_en_o | output | 1 | Comparator 2 enable (select non-zero) |
| cmp2_insel_o | output | 3 | Comparator 2 inverting-input code |
| cmp2_fast_o | output | 1 | Comparator 2 fast mode |
| pull_o | output | 4 | Pull-resistor enables |
| route_o | output | 7 | Timer trigger destinations |
| win_o | output | 1 | Registered window condition |
| evt1_o | output | 1 | Comparator 1 event pulse |
| evt2_o | output | 1 | Comparator 2 event pulse |
| evtw_o | output | 1 | Window event pulse |
| acq_irq_o | output | 1 | Acquisition interrupt |

## Verification
The assertions place no condition on the raw comparator inputs. They may change on any cycle, because the synchronisers absorb them. The assertions do rely on software writing whole words, and on the enable bits that gate an event being held for the cycle in which the pulse is registered. The stimulus writes at random intervals and toggles the raw inputs with about one chance in four per cycle. It biases writes toward an enabled first comparator and a non-zero select, so edges, window crossings and routing are exercised. Directed steps cover an all-ones write, routing code 7, and an acquisition set that lands on the same edge as a clear.

// File: rtl/dualcmp_pkg.sv
package dualcmp_pkg;
  localparam int CSR_W   = 32;
  localparam int ROUTE_N = 7;
  localparam int SEL_W   = 3;

  localparam int B_FALL2 = 31;
  localparam int B_FLAG  = 30;
  localparam int B_IE    = 29;
  localparam int B_RISE2 = 28;
  localparam int B_FALL1 = 27;
  localparam int B_RISE1 = 26;
  localparam int B_RT_LO = 21;
  localparam int B_IS_LO = 18;
  localparam int B_WIN   = 17;
  localparam int B_RISEW = 16;
  localparam int B_ST2   = 13;
  localparam int B_FAST  = 12;
  localparam int B_ST1   = 7;
  localparam int B_FALLW = 5;
  localparam int B_EN1   = 4;
  localparam int PULL_W  = 4;

  localparam logic [CSR_W-1:0] CSR_WMASK = 32'hBCFF_103F;
  localparam logic [SEL_W-1:0] RT_NONE   = 3'd7;
  localparam logic [SEL_W-1:0] IS_OFF    = 3'd0;
endpackage

// File: rtl/dualcmp_sync.sv
module dualcmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dualcmp_edge.sv
module dualcmp_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic pulse_o
);
  logic prev_q, pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= sig_i;
      pulse_q <= (sig_i & ~prev_q & rise_en_i) | (~sig_i & prev_q & fall_en_i);
    end
  end

  assign pulse_o = pulse_q;

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (sig_i && !prev_q && rise_en_i) |=> pulse_o); // R6
  AST_FALL_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!sig_i && prev_q && fall_en_i) |=> pulse_o); // R6
  AST_QUIET_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (sig_i == prev_q) |=> !pulse_o); // R6
endmodule

// File: rtl/dualcmp_route.sv
module dualcmp_route #(
  parameter int N     = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             data_i,
  output logic [N-1:0]     route_o
);
  logic [N-1:0] nxt, route_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_dest
      assign nxt[g] = data_i & (sel_i == SEL_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) route_q <= '0;
    else     route_q <= nxt;
  end

  assign route_o = route_q;

  AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(route_o)); // R5
  AST_ROUTE_NONE: assert property (@(posedge clk) disable iff (rst)
    (sel_i >= SEL_W'(N)) |=> (route_o == '0)); // R5
endmodule

// File: rtl/dualcmp_ctrl.sv
module dualcmp_ctrl
  import dualcmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [CSR_W-1:0]  wr_data_i,
  output logic [CSR_W-1:0]  rd_data_o,
  input  logic              cmp1_raw_i,
  input  logic              cmp2_raw_i,
  input  logic              acq_done_i,
  output logic              cmp1_en_o,
  output logic              cmp2_en_o,
  output logic [SEL_W-1:0]  cmp2_insel_o,
  output logic              cmp2_fast_o,
  output logic [PULL_W-1:0] pull_o,
  output logic [ROUTE_N-1:0] route_o,
  output logic              win_o,
  output logic              evt1_o,
  output logic              evt2_o,
  output logic              evtw_o,
  output logic              acq_irq_o
);
  logic [CSR_W-1:0] csr_q;
  logic             flag_q;
  logic             sync1, sync2;
  logic             st1, st2, win_c, win_q;
  logic [SEL_W-1:0] insel, rtsel;

  always_ff @(posedge clk) begin
    if (rst)          csr_q <= '0;
    else if (wr_en_i) csr_q <= wr_data_i & CSR_WMASK;
  end

  always_ff @(posedge clk) begin
    if (rst)                               flag_q <= 1'b0;
    else if (acq_done_i)                   flag_q <= 1'b1;
    else if (wr_en_i && !wr_data_i[B_IE])  flag_q <= 1'b0;
  end

  dualcmp_sync #(.STAGES(SYNC_STAGES)) u_sync1 (
    .clk(clk), .rst(rst), .d_i(cmp1_raw_i), .q_o(sync1));
  dualcmp_sync #(.STAGES(SYNC_STAGES)) u_sync2 (
    .clk(clk), .rst(rst), .d_i(cmp2_raw_i), .q_o(sync2));

  assign insel = csr_q[B_IS_LO +: SEL_W];
  assign rtsel = csr_q[B_RT_LO +: SEL_W];
  assign st1   = sync1 & csr_q[B_EN1];
  assign st2   = sync2 & (insel != IS_OFF);
  assign win_c = csr_q[B_WIN] & st1 & ~st2;

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else     win_q <= win_c;
  end

  dualcmp_edge u_edge1 (
    .clk(clk), .rst(rst), .sig_i(st1),
    .rise_en_i(csr_q[B_RISE1]), .fall_en_i(csr_q[B_FALL1]), .pulse_o(evt1_o));
  dualcmp_edge u_edge2 (
    .clk(clk), .rst(rst), .sig_i(st2),
    .rise_en_i(csr_q[B_RISE2]), .fall_en_i(csr_q[B_FALL2]), .pulse_o(evt2_o));
  dualcmp_edge u_edgew (
    .clk(clk), .rst(rst), .sig_i(win_c),
    .rise_en_i(csr_q[B_RISEW]), .fall_en_i(csr_q[B_FALLW]), .pulse_o(evtw_o));

  dualcmp_route #(.N(ROUTE_N), .SEL_W(SEL_W)) u_route (
    .clk(clk), .rst(rst), .sel_i(rtsel), .data_i(st2), .route_o(route_o));

  always_comb begin
    rd_data_o         = csr_q;
    rd_data_o[B_FLAG] = flag_q;
    rd_data_o[B_ST2]  = st2;
    rd_data_o[B_ST1]  = st1;
  end

  assign cmp1_en_o    = csr_q[B_EN1];
  assign cmp2_en_o    = (insel != IS_OFF);
  assign cmp2_insel_o = insel;
  assign cmp2_fast_o  = csr_q[B_FAST];
  assign pull_o       = csr_q[PULL_W-1:0];
  assign win_o        = win_q;
  assign acq_irq_o    = flag_q & csr_q[B_IE];

  AST_CMP2_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmp2_insel_o == IS_OFF) |-> !rd_data_o[B_ST2]); // R3
  AST_ACQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_data_i[B_IE] && !acq_done_i) |=> !rd_data_o[B_FLAG]); // R8
  AST_ACQ_SET: assert property (@(posedge clk) disable iff (rst)
    acq_done_i |=> rd_data_o[B_FLAG]); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o & ~(CSR_WMASK | 32'h4000_2080)) == '0); // R2
  AST_WIN_NEEDS_ST1: assert property (@(posedge clk) disable iff (rst)
    win_o |-> $past(rd_data_o[B_ST1])); // R7
endmodule

// File: tb/dualcmp_ctrl_tb.sv
module dualcmp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        raw1 = 1'b0, raw2 = 1'b0, acq = 1'b0;
  logic [31:0] rd_data;
  logic        en1, en2, fast, win, e1, e2, ew, irq;
  logic [2:0]  insel;
  logic [3:0]  pull;
  logic [6:0]  route;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [31:0] WMASK = 32'hBCFF_103F;

  always #10 clk = ~clk;

  dualcmp_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .cmp1_raw_i(raw1), .cmp2_raw_i(raw2), .acq_done_i(acq),
    .cmp1_en_o(en1), .cmp2_en_o(en2), .cmp2_insel_o(insel), .cmp2_fast_o(fast),
    .pull_o(pull), .route_o(route), .win_o(win), .evt1_o(e1), .evt2_o(e2),
    .evtw_o(ew), .acq_irq_o(irq));

  // reference model built from the requirements
  logic [31:0] m_csr;
  logic m_flag, m_a1, m_b1, m_a2, m_b2, m_pv1, m_pv2, m_pvw, m_p1, m_p2, m_pw, m_winq;
  logic [6:0] m_route;
  logic ms1, ms2, mwin;

  function automatic logic exp_st1(logic [31:0] c, logic s); return s & c[4]; endfunction
  function automatic logic exp_st2(logic [31:0] c, logic s); return s & (c[20:18] != 3'd0); endfunction
  function automatic logic [6:0] exp_route(logic [2:0] sel, logic d);
    return (sel == 3'd7) ? 7'd0 : (7'(d) << sel);
  endfunction
  function automatic logic exp_edge(logic cur, logic prev, logic re, logic fe);
    return (cur & ~prev & re) | (~cur & prev & fe);
  endfunction

  assign ms1  = exp_st1(m_csr, m_b1);
  assign ms2  = exp_st2(m_csr, m_b2);
  assign mwin = m_csr[17] & ms1 & ~ms2;

  always @(posedge clk) begin
    if (rst) begin
      m_csr <= '0; m_flag <= 0; m_a1 <= 0; m_b1 <= 0; m_a2 <= 0; m_b2 <= 0;
      m_pv1 <= 0; m_pv2 <= 0; m_pvw <= 0; m_p1 <= 0; m_p2 <= 0; m_pw <= 0;
      m_winq <= 0; m_route <= '0;
    end else begin
      if (wr_en) m_csr <= wr_data & WMASK;
      if (acq) m_flag <= 1'b1;
      else if (wr_en && !wr_data[29]) m_flag <= 1'b0;
      m_a1 <= raw1; m_b1 <= m_a1; m_a2 <= raw2; m_b2 <= m_a2;
      m_p1 <= exp_edge(ms1, m_pv1, m_csr[26], m_csr[27]);
      m_p2 <= exp_edge(ms2, m_pv2, m_csr[28], m_csr[31]);
      m_pw <= exp_edge(mwin, m_pvw, m_csr[16], m_csr[5]);
      m_pv1 <= ms1; m_pv2 <= ms2; m_pvw <= mwin;
      m_winq <= mwin;
      m_route <= exp_route(m_csr[23:21], ms2);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 writable bits", rd_data & WMASK, m_csr);
    chk("R2 reserved bits", rd_data & ~(WMASK | 32'h4000_2080), 32'd0);
    chk("R4 status bit 7", 32'(rd_data[7]), 32'(ms1));
    chk("R4 status bit 13", 32'(rd_data[13]), 32'(ms2));
    chk("R8 flag bit 30", 32'(rd_data[30]), 32'(m_flag));
    chk("R8 acq_irq", 32'(irq), 32'(m_flag & m_csr[29]));
    chk("R3 cmp2_en", 32'(en2), 32'(m_csr[20:18] != 3'd0));
    chk("R3 cmp2_insel", 32'(insel), 32'(m_csr[20:18]));
    chk("R9 en1/fast/pull", {25'd0, en1, fast, 1'b0, pull}, {25'd0, m_csr[4], m_csr[12], 1'b0, m_csr[3:0]});
    chk("R5 route", 32'(route), 32'(m_route));
    chk("R6 evt1", 32'(e1), 32'(m_p1));
    chk("R6 evt2", 32'(e2), 32'(m_p2));
    chk("R7 win", 32'(win), 32'(m_winq));
    chk("R7 evtw", 32'(ew), 32'(m_pw));
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 reset rd_data", rd_data, 32'd0);
    chk("R1 reset outputs", {18'd0, en1, en2, insel, fast, pull, win, e1, e2, ew, irq}, 32'd0);
    chk("R1 reset route", 32'(route), 32'd0);
    rst = 1'b0;
    step();
    chk("R1 first cycle after reset", rd_data, 32'd0);

    // R2: all-ones write, read-only and reserved bits untouched
    wr(32'hFFFF_FFFF);
    step();
    chk("R2 all-ones readback", rd_data & ~32'h4000_2080, WMASK);
    wr(32'h0000_0000);

    // R5: code 7 with comparator 2 high routes nowhere
    raw2 = 1'b1;
    wr({3'b000, 5'b0, 3'd7, 3'd2, 18'd0});
    repeat (4) step();
    chk("R5 code 7 all low", 32'(route), 32'd0);
    // R5: code 6 drives the last destination
    wr({3'b000, 5'b0, 3'd6, 3'd2, 18'd0});
    step();
    chk("R5 code 6 line", 32'(route), 32'h40);
    // R3: change select while enabled
    wr({3'b000, 5'b0, 3'd6, 3'd5, 18'd0});
    chk("R3 select change keeps enable", 32'(en2), 32'd1);

    // R8: set and clear on the same edge -> set wins
    acq = 1'b1;
    wr(32'h0);
    acq = 1'b0;
    chk("R8 set wins over clear", 32'(rd_data[30]), 32'd1);
    wr(32'h0);
    chk("R8 clear by bit29 zero", 32'(rd_data[30]), 32'd0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 9) < 7) begin
        d[4] = 1'b1;
        if (d[20:18] == 3'd0) d[18] = 1'b1;
      end
      if ($urandom_range(0, 3) == 0) raw1 = ~raw1;
      if ($urandom_range(0, 3) == 0) raw2 = ~raw2;
      acq = ($urandom_range(0, 15) == 0);
      wr_en = ($urandom_range(0, 11) == 0);
      wr_data = d;
      step();
    end
    wr_en = 1'b0; acq = 1'b0;
    step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule